// File: doc/BRIEF.md
# Write-Triggered SPI Master with Hold Registers

This block is an SPI master for a small 8-bit processor bus. It has two byte addresses. A byte transfer starts only when the processor writes the data address. Reads are pure lookups, so the extra bus reads a processor may make to nearby locations never move the serial bus. Each data write also captures one byte from the slave, which gives full-duplex operation. A one-byte transmit hold register lets software queue the next byte while the current one shifts. A matching receive hold register keeps the last complete byte until a newer one replaces it.

Chip select needs no handling by software. The first data write of a session pulls it low. A write of any value to the control address ends the session: chip select goes high and the master stops driving the clock and data lines, so another device can reach the flash. The serial format is fixed: clock idles low, data is sampled on the rising clock edge and changed on the falling edge, most significant bit first. Each half period of the serial clock lasts `HALF` system clocks.

The block is built around a four-state machine:

- `ST_OFF`: no session is open.
- `ST_IDLE`: a session is open and no byte is shifting.
- `ST_LOW`: the clock-low half of a bit.
- `ST_HIGH`: the clock-high half of a bit.

Its transitions are:

- OFF to IDLE on a data write.
- IDLE to LOW when the hold register is full.
- LOW to HIGH when the half period expires. The input bit is sampled on this transition.
- HIGH to LOW when the half period expires and bits remain, or when the byte is done and another byte is waiting.
- HIGH to IDLE when the byte is done and nothing is waiting.
- Any state to OFF on a control write.

Top module: `spi_wr_master`

## Requirements
- R1: After reset the session is closed: `spi_cs_n` is 1, both output enables are 0, the status read (offset 0) returns 0x01, and the data read (offset 1) returns 0x00.
- R2: A write of any value to offset 0 closes the session in the next cycle. `spi_cs_n` goes to 1 and `spi_sclk_oe`/`spi_mosi_oe` go to 0. A byte that is shifting or waiting is dropped, status bit 7 clears, and no further clock edges occur.
- R3: A write to offset 1 pulls `spi_cs_n` low in the next cycle if it was high, and the written byte is then transmitted.
- R4: Transmission uses mode 0, MSB first. `spi_mosi` holds each bit across its rising `spi_sclk` edge, and `spi_sclk` is low whenever no byte is shifting.
- R5: `spi_miso` is sampled on each rising `spi_sclk` edge, MSB first. When the eighth bit completes, the byte becomes readable at offset 1.
- R6: Status bit 7 is 1 from the data write until the last queued byte has finished, and 0 otherwise.
- R7: Status bit 6 inverts exactly once for each byte placed in the receive hold register.
- R8: Status bit 0 equals `spi_cs_n`, and status bits 5 to 1 read as 0.
- R9: A read at either offset starts no transfer and changes no state. Clock, status and received data stay as they were.
- R10: A byte written while another is shifting waits in the hold register. It is sent directly after the current byte, with `spi_cs_n` staying low.
- R11: A second write while the hold register is still full replaces the waiting byte. Only the latest one is transmitted.
- R12: Each `spi_sclk` high phase lasts `HALF` system clocks, so a byte keeps `spi_sclk` high for 8·`HALF` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on `bus_addr`) |
| spi_sclk | output | 1 | Serial clock value |
| spi_sclk_oe | output | 1 | Serial clock drive enable |
| spi_mosi | output | 1 | Serial data out value |
| spi_mosi_oe | output | 1 | Serial data out drive enable |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest case to reach is a write that lands while the hold register is already full and a byte is still shifting. The stimulus produces it by issuing data writes on consecutive bus cycles, so the first byte leaves the hold register and the next two contend for it. A second sequence waits for a rising serial clock edge before queuing a byte, which exercises the back-to-back handover without chip select rising. A bench slave model returns a byte computed from its own transfer count, and a full sweep of all 256 transmit values compares what the slave received with what the master captured.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } spi_state_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/spi_wr_timer.sv
module spi_wr_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (restart)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/spi_wr_engine.sv
module spi_wr_engine
    import spi_wr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop,
    input  logic          start,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          miso,
    output logic          take,
    output logic          byte_done,
    output logic [DW-1:0] rx_word,
    output spi_state_e    state,
    output logic          sclk,
    output logic          mosi,
    output logic          drive_oe,
    output logic          cs_n
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

    spi_state_e    state_q, state_nxt;
    logic [DW-1:0] tx_sh, rx_sh;
    logic [BW-1:0] bit_q;
    logic          expire, last, restart;

    assign last    = (bit_q == '0);
    assign restart = (state_nxt != state_q);

    spi_wr_timer #(.HALF(HALF)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expire  (expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF:  if (start) state_nxt = ST_IDLE;
            ST_IDLE: if (hold_full) state_nxt = ST_LOW;
            ST_LOW:  if (expire) state_nxt = ST_HIGH;
            ST_HIGH: begin
                if (expire) begin
                    if (!last || hold_full)
                        state_nxt = ST_LOW;
                    else
                        state_nxt = ST_IDLE;
                end
            end
        endcase
        if (stop)
            state_nxt = ST_OFF;
    end

    // handshake with the hold registers
    always_comb begin
        byte_done = !stop && (state_q == ST_HIGH) && expire && last;
        take      = !stop && hold_full &&
                    ((state_q == ST_IDLE) || byte_done);
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
            bit_q <= '0;
        end else if (!stop) begin
            if (take) begin
                tx_sh <= hold_data;
                bit_q <= TOP_BIT;
            end else if (state_q == ST_HIGH && expire && !last) begin
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
                bit_q <= bit_q - 1'b1;
            end
            if (state_q == ST_LOW && expire)
                rx_sh <= {rx_sh[DW-2:0], miso};
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        rx_word  = rx_sh;
        sclk     = (state_q == ST_HIGH);
        mosi     = (state_q == ST_OFF) ? 1'b0 : tx_sh[DW-1];
        drive_oe = (state_q != ST_OFF);
        cs_n     = (state_q == ST_OFF);
    end
endmodule

// File: rtl/spi_wr_master.sv
module spi_wr_master
    import spi_wr_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_sclk_oe,
    output logic       spi_mosi,
    output logic       spi_mosi_oe,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int DW = 8;

    logic          ctrl_wr, data_wr;
    logic          hold_full_q;
    logic [DW-1:0] hold_tx_q, rx_hold_q, rx_word;
    logic          toggle_q, take, byte_done, drive_oe, busy;
    spi_state_e    state;
    logic [7:0]    status_w;

    assign ctrl_wr = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
    assign data_wr = bus_sel && bus_we && (bus_addr == ADDR_DATA);

    spi_wr_engine #(.DW(DW), .HALF(HALF)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (ctrl_wr),
        .start     (data_wr),
        .hold_full (hold_full_q),
        .hold_data (hold_tx_q),
        .miso      (spi_miso),
        .take      (take),
        .byte_done (byte_done),
        .rx_word   (rx_word),
        .state     (state),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .drive_oe  (drive_oe),
        .cs_n      (spi_cs_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_tx_q   <= '0;
            rx_hold_q   <= '0;
            toggle_q    <= 1'b0;
        end else begin
            if (ctrl_wr)
                hold_full_q <= 1'b0;
            else if (data_wr)
                hold_full_q <= 1'b1;
            else if (take)
                hold_full_q <= 1'b0;
            if (data_wr)
                hold_tx_q <= bus_wdata;
            if (byte_done) begin
                rx_hold_q <= rx_word;
                toggle_q  <= ~toggle_q;
            end
        end
    end

    assign busy        = hold_full_q || (state == ST_LOW) || (state == ST_HIGH);
    assign status_w    = {busy, toggle_q, 5'b0, spi_cs_n};
    assign bus_rdata   = (bus_addr == ADDR_DATA) ? rx_hold_q : status_w;
    assign spi_sclk_oe = drive_oe;
    assign spi_mosi_oe = drive_oe;
endmodule

// File: rtl/spi_wr_master_chk.sv
module spi_wr_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic       bus_addr,
    input logic       spi_sclk,
    input logic       spi_sclk_oe,
    input logic       spi_mosi_oe,
    input logic       spi_cs_n,
    input logic [7:0] status
);
    // R2: control write closes the session one cycle later
    a_r2_ctrl_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_addr) |=> (spi_cs_n && !spi_sclk_oe && !spi_mosi_oe && !status[7]));

    // R2: while closed, nothing is driven and the clock is low
    a_r2_released_bus: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sclk_oe && !spi_mosi_oe && !spi_sclk));

    // R3: a data write opens the session one cycle later
    a_r3_data_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr) |=> !spi_cs_n);

    // R6: a clock-high phase only occurs while busy
    a_r6_busy_covers_clock: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> status[7]);

    // R7: the receive toggle only flips as a high phase ends
    a_r7_toggle_at_byte_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[6]) |-> $past(spi_sclk));

    // R9: a read while not busy never starts clocking
    a_r9_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !status[7]) |=> (!spi_sclk && !status[7]));

    // R8: unused status bits are zero
    a_r8_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:1] == 5'b0);
endmodule

bind spi_wr_master spi_wr_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .spi_sclk    (spi_sclk),
    .spi_sclk_oe (spi_sclk_oe),
    .spi_mosi_oe (spi_mosi_oe),
    .spi_cs_n    (spi_cs_n),
    .status      (status_w)
);

// File: tb/spi_wr_master_test.sv
`timescale 1ns/1ps
module spi_wr_master_test;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_sclk_oe, spi_mosi, spi_mosi_oe, spi_miso, spi_cs_n;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_wr_master #(.HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_sclk_oe(spi_sclk_oe), .spi_mosi(spi_mosi),
        .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // slave model
    function automatic logic [7:0] pat(input int k);
        return 8'((k * 53 + 29) & 255);
    endfunction

    int         s_bytes = 0;
    logic [2:0] s_bit = 3'd0;
    logic [2:0] f_cnt = 3'd0;
    logic [7:0] s_rx = 8'h00;
    logic [7:0] s_log [0:511];
    int         cs_rises = 0;
    int         high_cycles = 0;

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            s_bit <= 3'd0;
        end else begin
            s_rx  <= {s_rx[6:0], spi_mosi};
            s_bit <= s_bit + 3'd1;
            if (s_bit == 3'd7) begin
                s_log[s_bytes & 511] <= {s_rx[6:0], spi_mosi};
                s_bytes <= s_bytes + 1;
            end
        end
    end

    always @(negedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) f_cnt <= 3'd0;
        else          f_cnt <= f_cnt + 3'd1;
    end

    always @(posedge spi_cs_n) cs_rises <= cs_rises + 1;
    always @(negedge clk) if (spi_sclk) high_cycles <= high_cycles + 1;

    logic [7:0] cur_pat;
    assign cur_pat  = pat(s_bytes);
    assign spi_miso = spi_cs_n ? 1'b0 : cur_pat[3'd7 - f_cnt];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int i = 0; i < 2000; i++) begin
            rd(1'b0, st);
            if (!st[7]) return;
        end
        chk(1'b0, "R6 busy never cleared", 1, 0);
    endtask

    logic [7:0] st, d;
    int k0, hc0, cr0;
    logic tg0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(1'b0, st);
        chk(st == 8'h01, "R1 status after reset", st, 8'h01);
        rd(1'b1, d);
        chk(d == 8'h00, "R1 rx data after reset", d, 0);
        chk(spi_cs_n && !spi_sclk_oe && !spi_mosi_oe, "R1 bus released",
            {spi_cs_n, spi_sclk_oe, spi_mosi_oe}, 3'b100);

        // R9: reads in closed session are inert
        for (int i = 0; i < 10; i++) rd(1'(i), d);
        chk(spi_cs_n && s_bytes == 0, "R9 reads while closed", s_bytes, 0);

        // R3/R4/R5/R6/R7/R8/R12: sweep of all transmit values
        tg0 = 1'b0;
        for (int v = 0; v < 256; v++) begin
            k0  = s_bytes;
            hc0 = high_cycles;
            wr(1'b1, 8'(v));
            chk(!spi_cs_n, "R3 cs low after data write", spi_cs_n, 0);
            wait_idle();
            chk(s_bytes == k0 + 1 && s_log[k0 & 511] == 8'(v), "R4 slave byte",
                s_log[k0 & 511], v);
            rd(1'b1, d);
            chk(d == pat(k0), "R5 rx byte", d, pat(k0));
            rd(1'b0, st);
            chk(st[6] == ~tg0, "R7 toggle per byte", st[6], ~tg0);
            tg0 = st[6];
            chk(st[0] == 1'b0 && st[5:1] == 5'b0 && !st[7], "R8 status bits", st, {tg0, 6'b0});
            chk(high_cycles - hc0 == 8 * HALF, "R12 clock high time", high_cycles - hc0, 8 * HALF);
            chk(!spi_sclk, "R4 clock low when idle", spi_sclk, 0);
        end

        // R9: reads inside an open, idle session
        k0 = s_bytes; rd(1'b1, d); hc0 = high_cycles;
        for (int i = 0; i < 40; i++) rd(1'(i), st);
        rd(1'b0, st);
        chk(s_bytes == k0 && high_cycles == hc0 && !st[7] && st[6] == tg0, "R9 reads inert",
            high_cycles - hc0, 0);
        rd(1'b1, st);
        chk(st == d, "R9 rx data unchanged", st, d);

        // R10: queue a byte while one is shifting
        k0 = s_bytes; cr0 = cs_rises;
        wr(1'b1, 8'hA5);
        @(posedge spi_sclk);
        wr(1'b1, 8'h3C);
        rd(1'b0, st);
        chk(st[7], "R6 busy while queued", st[7], 1);
        wait_idle();
        chk(s_bytes == k0 + 2 && s_log[k0 & 511] == 8'hA5 && s_log[(k0 + 1) & 511] == 8'h3C,
            "R10 back-to-back order", s_log[(k0 + 1) & 511], 8'h3C);
        chk(cs_rises == cr0, "R10 cs held low", cs_rises - cr0, 0);
        rd(1'b1, d);
        chk(d == pat(k0 + 1), "R10 last rx byte", d, pat(k0 + 1));

        // R11: overwrite of a waiting byte
        k0 = s_bytes;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h11;
        @(negedge clk); bus_wdata = 8'h22;
        @(negedge clk); bus_wdata = 8'h33;
        @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
        wait_idle();
        chk(s_bytes == k0 + 2 && s_log[k0 & 511] == 8'h11 && s_log[(k0 + 1) & 511] == 8'h33,
            "R11 overwrite keeps latest", s_log[(k0 + 1) & 511], 8'h33);

        // R2: control write aborts mid-byte with a byte waiting
        k0 = s_bytes;
        wr(1'b1, 8'hF0);
        @(posedge spi_sclk);
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h5A);
        chk(spi_cs_n && !spi_sclk_oe && !spi_mosi_oe, "R2 bus released",
            {spi_cs_n, spi_sclk_oe, spi_mosi_oe}, 3'b100);
        rd(1'b0, st);
        chk(st[7] == 1'b0 && st[0] == 1'b1, "R2 status after close", st, {st[6], 6'b0, 1'b1});
        hc0 = high_cycles;
        repeat (60) @(negedge clk);
        chk(s_bytes == k0 && high_cycles == hc0, "R2 no further transfer", s_bytes - k0, 0);

        // R3: reopening after close
        k0 = s_bytes;
        wr(1'b1, 8'h81);
        chk(!spi_cs_n, "R3 reopen", spi_cs_n, 0);
        wait_idle();
        chk(s_log[k0 & 511] == 8'h81, "R3 byte after reopen", s_log[k0 & 511], 8'h81);
        wr(1'b0, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule